// File: doc/BRIEF.md
# NEC Frame Decoder from Run-Length Samples

This block takes the run-length byte stream of one received infrared packet and turns it into an NEC-style 32-bit code. Each input byte describes one run of the demodulated line. Bit 7 is the level, where 1 means a carrier pulse and 0 means a space. Bits 6:0 hold the run's duration in sample ticks. The decoder accepts one byte per clock over a valid/ready handshake. A separate packet-end strobe marks the end of the packet.

Runs of the same level are summed into one accumulator before any threshold is applied. This means a long mark or space split across several bytes is measured as a whole. The decoder first locates the leader pulse and then the leader space. After that, every following pulse/space pair yields one data bit. The bit's value is taken from the length of its space.

When the packet ends, the block presents the decoded word on registered outputs for one cycle, together with a done strobe. It also reports whether the command byte matches its complement, or raises an error strobe with an all-ones code. The decoder then returns to a fresh leader search.

Top module: `nec_run_decoder`

## Requirements
- R1: The pulse accumulator starts each packet preset to 80 ticks. On the first space byte, the leader pulse is accepted only if the summed pulse length is greater than 80. Otherwise that space byte is dropped, the accumulator clears to 0 and the search for a leader pulse continues.
- R2: After the leader pulse, spaces are summed starting with the accepting space byte. On the next pulse byte, the leader space is accepted only if the sum is greater than 40 ticks. Otherwise the sum clears and the space search continues.
- R3: Within a data bit, a summed pulse longer than 26 ticks, measured when its space begins, aborts the frame with an error.
- R4: A data bit's space is measured when the next pulse byte arrives. A space greater than 53 ticks is an error. A space greater than 26 ticks decodes as 1, and a space of 26 ticks or less decodes as 0.
- R5: Decoded bits fill the code least significant bit first. Decoding stops after 32 bits, and any bytes after that point have no effect on the result.
- R6: Any decode error reports code 0xFFFFFFFF with err=1 and valid=0.
- R7: valid=1 exactly when code bits 23:16 XOR code bits 31:24 equal 0xFF. Bits 15:0 (address) are not examined.
- R8: If a packet ends after the leader but before 32 bits, the partial code (unfilled bits 0) is reported with err=0 and validity from R7 alone. If a packet ends before the leader is complete, it is an error.
- R9: A packet-end strobe produces exactly one done cycle, on the clock after the strobe. A byte accepted in the same cycle as the strobe belongs to the ending packet.
- R10: The packet-end strobe restores the decoder to its R1 starting state, so the next packet is decoded independently of earlier ones.
- R11: in_ready is 0 during reset and 1 afterwards. After reset, out_done, out_valid, out_err and out_code are all 0.
- R12: Consecutive bytes of the same level (bit 7 = 1 pulse, 0 space) add into one run length before any threshold is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Run byte present |
| in_ready | output | 1 | Decoder can take a run byte |
| in_data | input | 8 | Bit 7 level (1 pulse), bits 6:0 duration in ticks |
| in_pkt_end | input | 1 | End of the current packet |
| out_code | output | 32 | Decoded code, or all ones on error |
| out_done | output | 1 | One-cycle result strobe |
| out_valid | output | 1 | Command/complement check passed |
| out_err | output | 1 | Decode error |

## Verification
The bench uses the default parameters: a 7-bit duration field, a 12-bit accumulator, thresholds of 80, 40, 26 and 53 ticks, and a 32-bit code. With these values every threshold and its neighbour (26/27, 40/41, 53/54, 80/81) can be produced by a single run byte. The same boundaries are also reached through split runs, which exercises the accumulation. A 211-tick leader has to span two bytes, so the byte-splitting path is used on every frame. Partial frames of 8 and 24 bits reach the R7 check without the full 32 bits.

// File: rtl/nec_rx_pkg.sv
package nec_rx_pkg;
  typedef enum logic [2:0] {
    SEEK_PULSE,
    SEEK_SPACE,
    BIT_PULSE,
    BIT_SPACE,
    FRAME_FULL,
    FRAME_BAD
  } dec_state_e;
endpackage

// File: rtl/nec_run_fsm.sv
module nec_run_fsm
  import nec_rx_pkg::*;
#(
  parameter int DUR_W          = 7,
  parameter int ACC_W          = 12,
  parameter int LEAD_PRESET    = 80,
  parameter int LEAD_PULSE_MIN = 80,
  parameter int LEAD_SPACE_MIN = 40,
  parameter int BIT_PULSE_MAX  = 26,
  parameter int BIT_SPACE_MID  = 26,
  parameter int BIT_SPACE_MAX  = 53
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_stb,
  input  logic             byte_lvl,
  input  logic [DUR_W-1:0] byte_dur,
  input  logic             pkt_end,
  input  logic             last_slot,
  output logic             bit_stb,
  output logic             bit_val,
  output dec_state_e       st_nx
);
  localparam logic [ACC_W-1:0] PRESET_V = ACC_W'(LEAD_PRESET);
  localparam logic [ACC_W-1:0] LP_MIN   = ACC_W'(LEAD_PULSE_MIN);
  localparam logic [ACC_W-1:0] LS_MIN   = ACC_W'(LEAD_SPACE_MIN);
  localparam logic [ACC_W-1:0] BP_MAX   = ACC_W'(BIT_PULSE_MAX);
  localparam logic [ACC_W-1:0] BS_MID   = ACC_W'(BIT_SPACE_MID);
  localparam logic [ACC_W-1:0] BS_MAX   = ACC_W'(BIT_SPACE_MAX);

  dec_state_e       st;
  logic [ACC_W-1:0] acc, acc_nx, dur_ext, acc_sum;
  logic [ACC_W:0]   sum_wide;

  assign dur_ext  = {{(ACC_W-DUR_W){1'b0}}, byte_dur};
  assign sum_wide = {1'b0, acc} + {1'b0, dur_ext};
  // saturate so very long runs never wrap below a threshold
  assign acc_sum  = sum_wide[ACC_W] ? '1 : sum_wide[ACC_W-1:0];

  always_comb begin
    st_nx   = st;
    acc_nx  = acc;
    bit_stb = 1'b0;
    bit_val = 1'b0;
    if (byte_stb) begin
      case (st)
        SEEK_PULSE: begin
          if (byte_lvl) acc_nx = acc_sum;
          else if (acc > LP_MIN) begin
            st_nx  = SEEK_SPACE;
            acc_nx = dur_ext;
          end else acc_nx = '0;
        end
        SEEK_SPACE: begin
          if (!byte_lvl) acc_nx = acc_sum;
          else if (acc > LS_MIN) begin
            st_nx  = BIT_PULSE;
            acc_nx = dur_ext;
          end else acc_nx = '0;
        end
        BIT_PULSE: begin
          if (byte_lvl) acc_nx = acc_sum;
          else if (acc > BP_MAX) st_nx = FRAME_BAD;
          else begin
            st_nx  = BIT_SPACE;
            acc_nx = dur_ext;
          end
        end
        BIT_SPACE: begin
          if (!byte_lvl) acc_nx = acc_sum;
          else if (acc > BS_MAX) st_nx = FRAME_BAD;
          else begin
            bit_stb = 1'b1;
            bit_val = (acc > BS_MID);
            st_nx   = last_slot ? FRAME_FULL : BIT_PULSE;
            acc_nx  = dur_ext;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pkt_end) begin
      st  <= SEEK_PULSE;
      acc <= PRESET_V;
    end else begin
      st  <= st_nx;
      acc <= acc_nx;
    end
  end

  AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> (st == SEEK_PULSE)); // R10
  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == FRAME_BAD && !pkt_end) |=> (st == FRAME_BAD)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == FRAME_FULL && !pkt_end) |=> (st == FRAME_FULL)); // R5
endmodule

// File: rtl/nec_bit_collect.sv
module nec_bit_collect #(
  parameter int CODE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              last_slot,
  output logic [CODE_W-1:0] code_nx
);
  localparam int CNT_W = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt;

  assign last_slot = (cnt == CNT_W'(CODE_W - 1));

  for (genvar g = 0; g < CODE_W; g++) begin : g_slot
    assign code_nx[g] = (bit_stb && cnt == CNT_W'(g)) ? bit_val : code[g];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code <= '0;
      cnt  <= '0;
    end else begin
      code <= code_nx;
      if (bit_stb) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(CODE_W)); // R5
  AST_NO_BIT_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(CODE_W)) |-> !bit_stb); // R5
endmodule

// File: rtl/nec_frame_check.sv
module nec_frame_check
  import nec_rx_pkg::*;
#(
  parameter int CODE_W  = 32,
  parameter int FIELD_W = 8,
  parameter int CMD_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_end,
  input  dec_state_e        st_nx,
  input  logic [CODE_W-1:0] code_nx,
  output logic [CODE_W-1:0] out_code,
  output logic              out_done,
  output logic              out_valid,
  output logic              out_err
);
  logic              bad;
  logic [CODE_W-1:0] result;
  logic              cmp_ok;

  assign bad    = (st_nx == SEEK_PULSE) || (st_nx == SEEK_SPACE) ||
                  (st_nx == FRAME_BAD);
  assign result = bad ? '1 : code_nx;
  assign cmp_ok = ((result[CMD_LSB +: FIELD_W] ^
                    result[CMD_LSB + FIELD_W +: FIELD_W]) == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_code  <= '0;
      out_done  <= 1'b0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else if (pkt_end) begin
      out_code  <= result;
      out_done  <= 1'b1;
      out_valid <= cmp_ok;
      out_err   <= bad;
    end else begin
      out_done  <= 1'b0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end
  end

  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    (out_done && out_err) |-> !out_valid); // R6
  AST_DONE_FOLLOWS_END: assert property (@(posedge clk) disable iff (rst)
    pkt_end |=> out_done); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_done |-> (!out_err && !out_valid)); // R9
endmodule

// File: rtl/nec_run_decoder.sv
module nec_run_decoder
  import nec_rx_pkg::*;
#(
  parameter int DUR_W          = 7,
  parameter int ACC_W          = 12,
  parameter int CODE_W         = 32,
  parameter int FIELD_W        = 8,
  parameter int CMD_LSB        = 16,
  parameter int LEAD_PRESET    = 80,
  parameter int LEAD_PULSE_MIN = 80,
  parameter int LEAD_SPACE_MIN = 40,
  parameter int BIT_PULSE_MAX  = 26,
  parameter int BIT_SPACE_MID  = 26,
  parameter int BIT_SPACE_MAX  = 53
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DUR_W:0]    in_data,
  input  logic              in_pkt_end,
  output logic [CODE_W-1:0] out_code,
  output logic              out_done,
  output logic              out_valid,
  output logic              out_err
);
  logic              byte_stb, bit_stb, bit_val, last_slot;
  logic [CODE_W-1:0] code_nx;
  dec_state_e        st_nx;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  assign byte_stb = in_valid && in_ready;

  nec_run_fsm #(
    .DUR_W(DUR_W), .ACC_W(ACC_W), .LEAD_PRESET(LEAD_PRESET),
    .LEAD_PULSE_MIN(LEAD_PULSE_MIN), .LEAD_SPACE_MIN(LEAD_SPACE_MIN),
    .BIT_PULSE_MAX(BIT_PULSE_MAX), .BIT_SPACE_MID(BIT_SPACE_MID),
    .BIT_SPACE_MAX(BIT_SPACE_MAX)
  ) u_fsm (
    .clk(clk), .rst(rst), .byte_stb(byte_stb),
    .byte_lvl(in_data[DUR_W]), .byte_dur(in_data[DUR_W-1:0]),
    .pkt_end(in_pkt_end), .last_slot(last_slot),
    .bit_stb(bit_stb), .bit_val(bit_val), .st_nx(st_nx)
  );

  nec_bit_collect #(.CODE_W(CODE_W)) u_collect (
    .clk(clk), .rst(rst), .clear(in_pkt_end), .bit_stb(bit_stb),
    .bit_val(bit_val), .last_slot(last_slot), .code_nx(code_nx)
  );

  nec_frame_check #(.CODE_W(CODE_W), .FIELD_W(FIELD_W), .CMD_LSB(CMD_LSB)) u_check (
    .clk(clk), .rst(rst), .pkt_end(in_pkt_end), .st_nx(st_nx),
    .code_nx(code_nx), .out_code(out_code), .out_done(out_done),
    .out_valid(out_valid), .out_err(out_err)
  );

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_ready); // R11
endmodule

// File: tb/nec_run_decoder_test.sv
`timescale 1ns/1ps
module nec_run_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_pkt_end;
  logic [7:0]  in_data;
  logic [31:0] out_code;
  logic        out_done, out_valid, out_err;

  always #2.5 clk = ~clk;

  nec_run_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_pkt_end(in_pkt_end), .out_code(out_code),
    .out_done(out_done), .out_valid(out_valid), .out_err(out_err)
  );

  typedef struct {
    logic [31:0] code;
    logic        vld;
    logic        err;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   split_mode = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic bit cmp_ok(input logic [31:0] c);
    return (c[23:16] ^ c[31:24]) == 8'hFF;
  endfunction

  task automatic expect_res(input logic [31:0] c, input logic v, input logic e,
                            input string tag);
    exp_t x;
    x.code = c; x.vld = v; x.err = e; x.tag = tag;
    expq.push_back(x);
  endtask

  task automatic expect_good(input logic [31:0] c, input string tag);
    expect_res(c, cmp_ok(c), 1'b0, tag);
  endtask

  task automatic expect_bad(input string tag);
    expect_res(32'hFFFF_FFFF, 1'b0, 1'b1, tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_done) begin
        n_chk++;
        if (expq.size() == 0) begin
          n_fail++;
          $display("FAIL R9: unexpected done, actual code %h expected none", out_code);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (out_code !== e.code || out_valid !== e.vld || out_err !== e.err) begin
            n_fail++;
            $display("FAIL %s: actual code=%h valid=%0b err=%0b expected code=%h valid=%0b err=%0b",
                     e.tag, out_code, out_valid, out_err, e.code, e.vld, e.err);
          end
        end
      end
    end
  end

  task automatic emit(input bit lvl, input int n);
    @(negedge clk);
    in_valid   = 1'b1;
    in_data    = {lvl, 7'(n)};
    in_pkt_end = 1'b0;
  endtask

  task automatic put(input bit lvl, input int dur);
    int left;
    left = dur;
    while (left > 0) begin
      int c;
      c = (left > 127) ? 127 : left;
      left -= c;
      if (split_mode && c >= 2) begin
        emit(lvl, c / 2);
        emit(lvl, c - c / 2);
      end else emit(lvl, c);
    end
  endtask

  task automatic close_pkt();
    @(negedge clk);
    in_valid   = 1'b0;
    in_pkt_end = 1'b1;
    @(negedge clk);
    in_pkt_end = 1'b0;
  endtask

  task automatic put_last(input bit lvl, input int n);
    @(negedge clk);
    in_valid   = 1'b1;
    in_data    = {lvl, 7'(n)};
    in_pkt_end = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
    in_pkt_end = 1'b0;
  endtask

  task automatic body(input logic [31:0] c, input int nb, input int p,
                      input int s0, input int s1);
    for (int i = 0; i < nb; i++) begin
      put(1'b1, p);
      put(1'b0, c[i] ? s1 : s0);
    end
  endtask

  task automatic frame(input logic [31:0] c, input int nb, input int p,
                       input int s0, input int s1, input bit samecyc);
    put(1'b1, 211);
    put(1'b0, 105);
    body(c, nb, p, s0, s1);
    if (samecyc) put_last(1'b1, 13);
    else begin
      put(1'b1, 13);
      close_pkt();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_pkt_end = 1'b0; in_data = 8'h00;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b0, "R11 ready low in reset", {31'b0, in_ready}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R11 ready after reset", {31'b0, in_ready}, 32'h1);
    check({out_done, out_valid, out_err} == 3'b000, "R11 strobes idle",
          {29'b0, out_done, out_valid, out_err}, 32'h0);
    check(out_code == 32'h0, "R11 code reset", out_code, 32'h0);

    // R7: matching command, and mismatching command
    expect_good(32'hBA45_FF00, "R7 valid frame");
    frame(32'hBA45_FF00, 32, 13, 13, 40, 0);
    expect_good(32'h1234_5678, "R7 mismatch");
    frame(32'h1234_5678, 32, 13, 13, 40, 0);
    expect_good(32'hB44B_1234, "R7 address ignored");
    frame(32'hB44B_1234, 32, 13, 13, 40, 0);

    // R12: every run split into two same-level bytes
    split_mode = 1;
    expect_good(32'h7F80_A55A, "R12 split runs");
    frame(32'h7F80_A55A, 32, 13, 13, 40, 0);
    split_mode = 0;

    // R3: pulse limits
    expect_bad("R3 pulse 27 error");
    frame(32'hBA45_FF00, 32, 27, 13, 40, 0);
    expect_good(32'hE11E_0F0F, "R3 pulse 26 accepted");
    frame(32'hE11E_0F0F, 32, 26, 13, 40, 0);

    // R4: space thresholds
    expect_good(32'hC33C_9669, "R4 space 53 is one, 26 is zero");
    frame(32'hC33C_9669, 32, 13, 26, 53, 0);
    expect_good(32'h8877_1122, "R4 space 27 is one");
    frame(32'h8877_1122, 32, 13, 1, 27, 0);
    expect_bad("R4 space 54 error");
    frame(32'hC33C_9669, 32, 13, 13, 54, 0);

    // R1: leader search
    expect_good(32'hF00F_ABCD, "R1 preset plus 1 tick");
    put(1'b1, 1); put(1'b0, 105); body(32'hF00F_ABCD, 32, 13, 13, 40);
    put(1'b1, 13); close_pkt();
    expect_bad("R1 pulse 80 after clear rejected");
    put(1'b0, 5); put(1'b1, 80); put(1'b0, 105); body(32'hF00F_ABCD, 32, 13, 13, 40);
    put(1'b1, 13); close_pkt();
    expect_good(32'hF00F_ABCD, "R1 pulse 81 after clear");
    put(1'b0, 5); put(1'b1, 81); put(1'b0, 105); body(32'hF00F_ABCD, 32, 13, 13, 40);
    put(1'b1, 13); close_pkt();
    expect_good(32'h55AA_0001, "R1 short pulse then real leader");
    put(1'b0, 10); put(1'b1, 50); put(1'b0, 10); put(1'b1, 100); put(1'b0, 105);
    body(32'h55AA_0001, 32, 13, 13, 40); put(1'b1, 13); close_pkt();

    // R2: leader space threshold
    expect_bad("R2 space 40 rejected");
    put(1'b1, 211); put(1'b0, 40); body(32'hBA45_FF00, 32, 13, 13, 40);
    put(1'b1, 13); close_pkt();
    expect_good(32'hBA45_FF00, "R2 space 41 accepted");
    put(1'b1, 211); put(1'b0, 41); body(32'hBA45_FF00, 32, 13, 13, 40);
    put(1'b1, 13); close_pkt();

    // R8: early end
    expect_good(32'h0000_005A, "R8 partial 8 bits");
    frame(32'h0000_005A, 8, 13, 13, 40, 0);
    expect_good(32'h00FF_1234, "R8 partial 24 bits valid");
    frame(32'h00FF_1234, 24, 13, 13, 40, 0);
    expect_bad("R8 end during leader");
    put(1'b1, 211); close_pkt();

    // R5: bytes after 32 bits ignored
    expect_good(32'hFE01_0080, "R5 trailing bytes ignored");
    put(1'b1, 211); put(1'b0, 105); body(32'hFE01_0080, 32, 13, 13, 40);
    put(1'b1, 13); put(1'b0, 100); put(1'b1, 100); put(1'b0, 120); close_pkt();

    // R9: byte in the end cycle belongs to the packet
    expect_good(32'hDF20_4242, "R9 same-cycle end");
    frame(32'hDF20_4242, 32, 13, 13, 40, 1);

    // R10: truncated packet then fresh packet; empty packet
    expect_bad("R10 truncated packet");
    put(1'b1, 211); put(1'b0, 20); close_pkt();
    expect_good(32'hBA45_FF00, "R10 fresh after truncated");
    frame(32'hBA45_FF00, 32, 13, 13, 40, 0);
    expect_bad("R10 empty packet");
    close_pkt();

    repeat (6) @(negedge clk);
    check(expq.size() == 0, "R9 all results delivered", 32'(expq.size()), 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule